// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block watches for a runaway program. A binary counter advances every clock while the watchdog runs. When the counter bit picked by a two-bit span field reaches its terminal count, the block emits a one-cycle interrupt. If software has also linked the timeout to reset, it emits a one-cycle reset request as well. The counter then wraps and keeps counting. Healthy software refreshes the counter by writing a kick byte to a write-only command register.

Switching the watchdog off takes two separate actions. Software first clears the enable bit in the mode register, then writes a stop byte to the command register. Clearing the enable bit on its own leaves the counter running. The stop byte on its own only refreshes the counter. Writing the enable bit back to 1 restarts the watchdog at once, and no key is needed for that.

Both registers sit behind one register write port with a one-bit select. The mode register can be read back through a combinational read port.

Top module: `kd_wdt`

## Requirements
- R1: After reset the mode register reads 0x04 (span 00, enable 1, reset link 0), irq_o and rst_req_o are low, and the first interrupt arrives 2^BASE_EXP cycles after reset is released.
- R2: The timeout for span value s is 2^(BASE_EXP + STEP*s) clock cycles. irq_o is high for exactly one cycle per timeout, and it repeats with the same period while no refresh is written.
- R3: Writing 0x4E to the command register clears the counter. The next interrupt comes 2^(BASE_EXP + STEP*span) cycles after the write.
- R4: Clearing the enable bit alone does not stop the watchdog. After enable is 0, writing 0xB1 to the command register stops counting, and no interrupt follows.
- R5: Writing 0xB1 while the enable bit is 1 clears the counter and leaves the watchdog running.
- R6: Writing the mode register with enable 1 restarts a stopped watchdog from a count of zero.
- R7: With the reset link at 1, rst_req_o pulses in the same cycle as irq_o. With the reset link at 0, rst_req_o stays low.
- R8: A command byte other than 0xB1 or 0x4E changes neither the counter nor the running state.
- R9: Reading with rd_sel_i = 0 returns {4'b0, reset link, enable, span[1:0]}. Reading with rd_sel_i = 1 returns zero.
- R10: A refresh write that lands in the terminal-count cycle suppresses that interrupt. The full period then restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Counter and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 mode, 1 command |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 1 | Read target: 0 mode, 1 command |
| rd_data_o | output | 8 | Read data |
| irq_o | output | 1 | One-cycle timeout interrupt |
| rst_req_o | output | 1 | One-cycle reset request on timeout when linked |

## Verification
A refresh write can reach the counter in the very cycle the selected bit hits its terminal count, so the clear and the timeout compete. The bench aligns a kick write with that edge by counting cycles from an earlier kick. It then expects no interrupt at that edge and a full period measured from the write. Separately, the reset request and the interrupt are judged together at each timeout, because they are meant to coincide.

// File: rtl/kd_wdt_pkg.sv
package kd_wdt_pkg;
  localparam logic [7:0] KEY_STOP = 8'hB1;
  localparam logic [7:0] KEY_KICK = 8'h4E;

  typedef struct packed {
    logic       rst_link;
    logic       enable;
    logic [1:0] span;
  } mode_t;

  localparam mode_t MODE_RST = '{rst_link: 1'b0, enable: 1'b1, span: 2'b00};
  localparam int    N_SPANS  = 4;

  typedef enum logic {SEL_MODE = 1'b0, SEL_CMD = 1'b1} reg_sel_e;
endpackage

// File: rtl/kd_wdt_regs.sv
module kd_wdt_regs
  import kd_wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_sel_i,
  output logic [7:0] rd_data_o,
  output mode_t      mode_o,
  output logic       kick_o,
  output logic       stop_o,
  output logic       arm_o
);
  mode_t mode_q;
  logic  mode_wr, cmd_wr;

  assign mode_wr = wr_en_i && (wr_sel_i == SEL_MODE);
  assign cmd_wr  = wr_en_i && (wr_sel_i == SEL_CMD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= MODE_RST;
    else if (mode_wr) mode_q <= mode_t'(wr_data_i[3:0]);
  end

  // both keys clear the counter; the stop key halts only once enable is low
  assign kick_o = cmd_wr && (wr_data_i == KEY_KICK || wr_data_i == KEY_STOP);
  assign stop_o = cmd_wr && (wr_data_i == KEY_STOP) && !mode_q.enable;
  assign arm_o  = mode_wr && wr_data_i[2];

  assign mode_o    = mode_q;
  assign rd_data_o = (rd_sel_i == SEL_MODE) ? {4'b0000, mode_q} : 8'h00;
endmodule

// File: rtl/kd_wdt_ctr.sv
module kd_wdt_ctr
  import kd_wdt_pkg::*;
#(
  parameter int BASE_EXP = 15,
  parameter int STEP     = 2,
  localparam int CNT_W   = BASE_EXP + (N_SPANS - 1) * STEP
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       stop_i,
  input  logic       arm_i,
  input  logic [1:0] span_i,
  output logic       run_o,
  output logic       tc_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic               run_q;
  logic [N_SPANS-1:0] tap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= 1'b1;
    else if (stop_i) run_q <= 1'b0;
    else if (arm_i)  run_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (run_q)  cnt_q <= cnt_q + 1'b1;
  end

  for (genvar i = 0; i < N_SPANS; i++) begin : g_tap
    localparam int E = BASE_EXP + i * STEP;
    assign tap[i] = &cnt_q[E-1:0];
  end

  // a refresh in the terminal cycle wins over the timeout
  assign tc_o  = run_q && !clr_i && tap[span_i];
  assign run_o = run_q;
endmodule

// File: rtl/kd_wdt_evt.sv
module kd_wdt_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tc_i,
  input  logic rst_link_i,
  output logic irq_o,
  output logic rst_req_o
);
  logic irq_q, rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      irq_q <= tc_i;
      rst_q <= tc_i && rst_link_i;
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = rst_q;
endmodule

// File: rtl/kd_wdt.sv
module kd_wdt
  import kd_wdt_pkg::*;
#(
  parameter int BASE_EXP = 15,
  parameter int STEP     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_sel_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_sel_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  output logic       rst_req_o
);
  mode_t mode_w;
  logic  kick_w, stop_w, arm_w, run_w, tc_w, en_w;

  assign en_w = mode_w.enable;

  kd_wdt_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .rd_sel_i  (rd_sel_i),
    .rd_data_o (rd_data_o),
    .mode_o    (mode_w),
    .kick_o    (kick_w),
    .stop_o    (stop_w),
    .arm_o     (arm_w)
  );

  kd_wdt_ctr #(.BASE_EXP(BASE_EXP), .STEP(STEP)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (kick_w),
    .stop_i (stop_w),
    .arm_i  (arm_w),
    .span_i (mode_w.span),
    .run_o  (run_w),
    .tc_o   (tc_w)
  );

  kd_wdt_evt u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tc_i       (tc_w),
    .rst_link_i (mode_w.rst_link),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
  );
endmodule

// File: rtl/kd_wdt_chk.sv
module kd_wdt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic       rd_sel_i,
  input logic [7:0] rd_data_o,
  input logic       irq_o,
  input logic       rst_req_o,
  input logic       run_i,
  input logic       en_i
);
  logic cmd_wr;
  assign cmd_wr = wr_en_i && wr_sel_i;

  a_r7_rst_with_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> irq_o);

  a_r2_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  a_r4_stop_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wr_data_i == 8'hB1 && !en_i) |=> !run_i);

  a_r4_stopped_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !(wr_en_i && !wr_sel_i && wr_data_i[2])) |=> !irq_o);

  a_r5_stop_key_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wr_data_i == 8'hB1 && en_i) |=> run_i);

  a_r6_rearm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_sel_i && wr_data_i[2]) |=> run_i);

  a_r8_other_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && wr_data_i != 8'hB1 && wr_data_i != 8'h4E) |=> $stable(run_i));

  a_r10_kick_masks_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_wr && (wr_data_i == 8'h4E || wr_data_i == 8'hB1)) |=> !irq_o);

  a_r9_cmd_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i |-> (rd_data_o == 8'h00));
endmodule

bind kd_wdt kd_wdt_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .run_i     (run_w),
  .en_i      (en_w)
);

// File: tb/kd_wdt_test.sv
module kd_wdt_test;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_EXP   = 3;
  localparam int STEP       = 2;
  localparam int LIMIT      = 4000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       irq, rst_req;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kd_wdt #(.BASE_EXP(BASE_EXP), .STEP(STEP)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .rd_sel_i  (rd_sel),
    .rd_data_o (rd_data),
    .irq_o     (irq),
    .rst_req_o (rst_req)
  );

  function automatic int period(input int s);
    return 1 << (BASE_EXP + STEP * s);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // called at a negedge; write lands on the next posedge
  task automatic wr(input bit sel, input logic [7:0] d);
    wr_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // cycles from the last edge until irq is seen
  task automatic measure(output int n, output bit rst_seen);
    n = 0;
    rst_seen = 1'b0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < LIMIT);
    rst_seen = rst_req;
  endtask

  task automatic idle_quiet(input int k, output bit seen);
    seen = 1'b0;
    repeat (k) begin
      @(negedge clk);
      if (irq) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int n;
    bit r, q;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0 && rst_req == 1'b0, "R1 outputs in reset", {irq, rst_req}, 0);
    rst_n = 1'b1;
    chk(rd_data == 8'h04, "R1 mode reset value", rd_data, 4);
    measure(n, r);
    chk(n == period(0), "R1 first timeout", n, period(0));

    // R2 / R7: all spans, link off, two periods each
    for (int s = 0; s < 4; s++) begin
      wr(1'b0, 8'(4 | s));
      wr(1'b1, 8'h4E);
      measure(n, r);
      chk(n == period(s), "R2 period", n, period(s));
      chk(r == 1'b0, "R7 no reset when unlinked", r, 0);
      @(negedge clk);
      chk(irq == 1'b0, "R2 single-cycle pulse", irq, 0);
      measure(n, r);
      chk(n == period(s) - 1, "R2 wrap period", n + 1, period(s));
    end

    // R7: link on
    for (int s = 0; s < 2; s++) begin
      wr(1'b0, 8'(12 | s));
      wr(1'b1, 8'h4E);
      measure(n, r);
      chk(n == period(s), "R7 period linked", n, period(s));
      chk(r == 1'b1, "R7 reset with irq", r, 1);
    end
    wr(1'b0, 8'h04);

    // R3: kick mid-count
    wr(1'b1, 8'h4E);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'h4E);
    measure(n, r);
    chk(n == period(0), "R3 kick restarts count", n, period(0));

    // R5: stop key while enabled
    wr(1'b1, 8'h4E);
    repeat (5) @(negedge clk);
    wr(1'b1, 8'hB1);
    measure(n, r);
    chk(n == period(0), "R5 stop key clears and runs", n, period(0));
    chk(rd_data[2] == 1'b1, "R5 enable kept", rd_data[2], 1);

    // R10: kick lands on terminal-count edge
    wr(1'b1, 8'h4E);
    idle_quiet(period(0) - 1, q);
    wr(1'b1, 8'h4E);
    chk(q == 1'b0 && irq == 1'b0, "R10 pulse suppressed", irq, 0);
    measure(n, r);
    chk(n == period(0), "R10 full period after collision", n, period(0));

    // R4: enable cleared alone keeps running
    wr(1'b0, 8'h00);
    wr(1'b1, 8'h4E);
    measure(n, r);
    chk(n == period(0), "R4 enable low still counts", n, period(0));

    // R8: every other command byte ignored (enable low, so no stop either)
    for (int b = 0; b < 256; b++) begin
      if (b == 8'hB1 || b == 8'h4E) continue;
      wr(1'b1, 8'h4E);
      repeat (3) @(negedge clk);
      wr(1'b1, 8'(b));
      measure(n, r);
      chk(n == period(0) - 4, "R8 foreign byte ignored", n, period(0) - 4);
    end

    // R4: stop key with enable low
    wr(1'b1, 8'hB1);
    idle_quiet(600, q);
    chk(q == 1'b0, "R4 stopped no irq", q, 0);
    chk(rd_data == 8'h00, "R4 mode after stop", rd_data, 0);

    // R6: re-enable
    wr(1'b0, 8'h04);
    measure(n, r);
    chk(n == period(0), "R6 restart from zero", n, period(0));

    // R9: readback sweep
    for (int v = 0; v < 16; v++) begin
      wr(1'b0, 8'(8'hF0 | v));
      rd_sel = 1'b0;
      #1;
      chk(rd_data == 8'(v), "R9 mode readback", rd_data, v);
      rd_sel = 1'b1;
      #1;
      chk(rd_data == 8'h00, "R9 command reads zero", rd_data, 0);
      rd_sel = 1'b0;
    end

    summary();
    $finish;
  end
endmodule